// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two word-aligned 32-bit stack pointers: a main pointer and a process pointer. Only the pointer chosen by the current execution state appears on the ordinary stack-register read/write port. Handler mode always works on the main pointer. Thread code uses whichever pointer a select bit names. The other pointer stays hidden from the ordinary port. It can be reached only through a second pair of ports that name a bank explicitly.

The block also sequences single-word pushes and pops on a stack that grows downward and whose pointer marks the last word written.

- **Push:** the block presents the lowered address and a write strobe in the cycle the request arrives. The pointer takes the lowered value at the next clock edge.
- **Pop:** the block presents the current address and a read strobe. The pointer is raised by one word at the next edge.
- **Collisions:** a direct write aimed at the pointer that a push or pop would update takes precedence. The transfer is dropped and flagged as a conflict.

Top module: `stack_bank_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the main pointer loads `main_reset_val` with bits 1:0 cleared, the process pointer loads zero, and the ports then show these values.
- R2: `active_bank` is 0 (main) whenever `handler_mode` is 1; otherwise it equals `thread_use_proc` (1 = process).
- R3: `gen_rd_data` shows the active pointer, and a `gen_wr_en` write changes only the active pointer from the next edge; the other pointer keeps its value.
- R4: Bits 1:0 of both pointers always read as zero; written values in those bits are dropped.
- R5: With `stack_op` = 2'b01 (push) and no conflict, `mem_wr` is 1, `mem_addr` equals the active pointer minus 4 (modulo 2^32), and `mem_wdata` equals `push_data`, all in the same cycle; from the next edge the active pointer holds that address.
- R6: With `stack_op` = 2'b10 (pop) and no conflict, `mem_rd` is 1 and `mem_addr` equals the active pointer in the same cycle; from the next edge the active pointer is 4 higher.
- R7: With `stack_op` = 2'b00 or 2'b11, neither strobe nor `conflict_err` is raised, and neither pointer changes unless a direct write occurs.
- R8: `spec_rd_data` shows the pointer chosen by `spec_rd_sel`, and a `spec_wr_en` write updates the pointer chosen by `spec_wr_sel` (0 = main, 1 = process) regardless of mode.
- R9: When a push or pop coincides with a `spec_wr_en` write to the active bank, `conflict_err` is 1 in that cycle, both strobes stay 0, and the pointer takes the written value.
- R10: When a push or pop coincides with `gen_wr_en`, `conflict_err` is 1, both strobes stay 0, and the active pointer takes the written value. When `gen_wr_en` and a `spec_wr_en` write hit the same bank, the `spec_wr_en` value is kept.
- R11: A `spec_wr_en` write to the inactive bank during a push or pop raises no conflict; both updates take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_reset_val | input | 32 | Value loaded into the main pointer at reset |
| handler_mode | input | 1 | 1 while an exception handler runs |
| thread_use_proc | input | 1 | Thread code uses the process pointer when 1 |
| stack_op | input | 2 | 00 idle, 01 push, 10 pop, 11 idle |
| push_data | input | 32 | Word to store on a push |
| gen_wr_en | input | 1 | Write the active pointer |
| gen_wr_data | input | 32 | Data for the active-pointer write |
| gen_rd_data | output | 32 | Active pointer value |
| spec_wr_en | input | 1 | Write a pointer named by `spec_wr_sel` |
| spec_wr_sel | input | 1 | Bank for the named write (0 main, 1 process) |
| spec_wr_data | input | 32 | Data for the named write |
| spec_rd_sel | input | 1 | Bank for the named read |
| spec_rd_data | output | 32 | Value of the named pointer |
| active_bank | output | 1 | Selected bank (0 main, 1 process) |
| mem_addr | output | 32 | Word address of the transfer |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wdata | output | 32 | Data to write |
| conflict_err | output | 1 | Transfer dropped because of a direct write |

## Verification
The functions that can coincide are a push or pop and a direct pointer write.

The bench provokes the overlap in three ways:
- a transfer issued in the same cycle as an active-port write;
- a transfer issued with a named write to the active bank;
- a transfer issued with a named write to the inactive bank.

For each cycle, a reference model in the bench predicts the strobe, the error flag and both pointer values seen through the read ports. The bench then judges the collision by whether the strobe is dropped, the flag is raised only on a true collision, and the written value survives while the transfer leaves no trace.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

    parameter int unsigned WORD_W  = 32;
    parameter int unsigned ALIGN_W = 2;
    localparam int unsigned PTR_W     = WORD_W - ALIGN_W;
    localparam int unsigned NUM_BANKS = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_RSVD = 2'b11
    } stack_op_e;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_PROC = 1'b1
    } bank_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        word_t addr;
    } mem_req_t;

    typedef struct packed {
        logic en;
        ptr_t val;
    } ptr_upd_t;

    function automatic word_t to_word(ptr_t p);
        return {p, {ALIGN_W{1'b0}}};
    endfunction

    function automatic ptr_t to_ptr(word_t w);
        return w[WORD_W-1:ALIGN_W];
    endfunction

    function automatic logic is_xfer(stack_op_e op);
        return (op == OP_PUSH) || (op == OP_POP);
    endfunction

endpackage

// File: rtl/sp_bank_select.sv
module sp_bank_select
    import sp_bank_pkg::*;
(
    input  logic  handler_mode,
    input  logic  thread_use_proc,
    output bank_e active
);
    always_comb begin
        if (handler_mode) active = BANK_MAIN;
        else              active = thread_use_proc ? BANK_PROC : BANK_MAIN;
    end
endmodule

// File: rtl/sp_stack_seq.sv
module sp_stack_seq
    import sp_bank_pkg::*;
(
    input  stack_op_e op,
    input  ptr_t      cur,
    input  word_t     push_data,
    input  logic      blocked,
    output mem_req_t  req,
    output word_t     wdata,
    output ptr_upd_t  upd
);
    ptr_t lowered;
    assign lowered = cur - ptr_t'(1);

    always_comb begin
        req      = '0;
        upd      = '0;
        wdata    = push_data;
        req.addr = to_word(cur);
        unique case (op)
            OP_PUSH: begin
                req.addr = to_word(lowered);
                if (!blocked) begin
                    req.wr  = 1'b1;
                    upd.en  = 1'b1;
                    upd.val = lowered;
                end
            end
            OP_POP: begin
                if (!blocked) begin
                    req.rd  = 1'b1;
                    upd.en  = 1'b1;
                    upd.val = cur + ptr_t'(1);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sp_bank_reg.sv
module sp_bank_reg
    import sp_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ptr_t     rst_val,
    input  ptr_upd_t upd,
    output ptr_t     q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= rst_val;
        else if (upd.en) q <= upd.val;
    end
endmodule

// File: rtl/stack_bank_unit.sv
module stack_bank_unit
    import sp_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] main_reset_val,
    input  logic              handler_mode,
    input  logic              thread_use_proc,
    input  logic [1:0]        stack_op,
    input  logic [WORD_W-1:0] push_data,
    input  logic              gen_wr_en,
    input  logic [WORD_W-1:0] gen_wr_data,
    output logic [WORD_W-1:0] gen_rd_data,
    input  logic              spec_wr_en,
    input  logic              spec_wr_sel,
    input  logic [WORD_W-1:0] spec_wr_data,
    input  logic              spec_rd_sel,
    output logic [WORD_W-1:0] spec_rd_data,
    output logic              active_bank,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              conflict_err
);
    bank_e     active;
    stack_op_e op;
    ptr_t      bank_q   [NUM_BANKS];
    ptr_t      bank_rst [NUM_BANKS];
    ptr_upd_t  bank_upd [NUM_BANKS];
    ptr_t      cur;
    mem_req_t  req;
    word_t     wdata;
    ptr_upd_t  seq_upd;
    logic      spec_hit_active;
    logic      blocked;

    assign op = stack_op_e'(stack_op);

    sp_bank_select u_sel (
        .handler_mode    (handler_mode),
        .thread_use_proc (thread_use_proc),
        .active          (active)
    );

    assign cur             = bank_q[active];
    assign spec_hit_active = spec_wr_en && (spec_wr_sel == active);
    assign blocked         = gen_wr_en || spec_hit_active;

    sp_stack_seq u_seq (
        .op        (op),
        .cur       (cur),
        .push_data (push_data),
        .blocked   (blocked),
        .req       (req),
        .wdata     (wdata),
        .upd       (seq_upd)
    );

    assign bank_rst[BANK_MAIN] = to_ptr(main_reset_val);
    assign bank_rst[BANK_PROC] = '0;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic is_active;
        logic spec_hit;
        assign is_active = (active == bank_e'(b));
        assign spec_hit  = spec_wr_en && (spec_wr_sel == b[0]);

        always_comb begin
            bank_upd[b] = '0;
            if (spec_hit) begin
                bank_upd[b].en  = 1'b1;
                bank_upd[b].val = to_ptr(spec_wr_data);
            end else if (gen_wr_en && is_active) begin
                bank_upd[b].en  = 1'b1;
                bank_upd[b].val = to_ptr(gen_wr_data);
            end else if (is_active) begin
                bank_upd[b] = seq_upd;
            end
        end

        sp_bank_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .rst_val (bank_rst[b]),
            .upd     (bank_upd[b]),
            .q       (bank_q[b])
        );
    end

    assign gen_rd_data  = to_word(cur);
    assign spec_rd_data = to_word(bank_q[spec_rd_sel]);
    assign active_bank  = active;
    assign mem_addr     = req.addr;
    assign mem_wr       = req.wr;
    assign mem_rd       = req.rd;
    assign mem_wdata    = wdata;
    assign conflict_err = is_xfer(op) && blocked;

endmodule

// File: rtl/sp_bank_checks.sv
module sp_bank_checks
    import sp_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              handler_mode,
    input logic              thread_use_proc,
    input logic [1:0]        stack_op,
    input logic [WORD_W-1:0] push_data,
    input logic [WORD_W-1:0] gen_rd_data,
    input logic              spec_wr_en,
    input logic              spec_wr_sel,
    input logic [WORD_W-1:0] spec_wr_data,
    input logic              spec_rd_sel,
    input logic [WORD_W-1:0] spec_rd_data,
    input logic              active_bank,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              conflict_err
);
    p_align_r4: assert property (@(posedge clk) disable iff (rst)
        (gen_rd_data[1:0] == 2'b00) && (spec_rd_data[1:0] == 2'b00));

    p_handler_main_r2: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> (active_bank == 1'b0));

    p_thread_sel_r2: assert property (@(posedge clk) disable iff (rst)
        !handler_mode |-> (active_bank == thread_use_proc));

    p_push_addr_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ((mem_addr == gen_rd_data - 32'd4) && (mem_wdata == push_data)));

    p_pop_addr_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == gen_rd_data));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr, mem_rd}));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (stack_op == 2'b00 || stack_op == 2'b11) |-> (!mem_wr && !mem_rd && !conflict_err));

    p_conflict_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        conflict_err |-> (!mem_wr && !mem_rd));

    p_spec_persist_r8: assert property (@(posedge clk) disable iff (rst)
        spec_wr_en |=> ((spec_rd_sel != $past(spec_wr_sel)) ||
                        (spec_rd_data == {$past(spec_wr_data[WORD_W-1:2]), 2'b00})));
endmodule

bind stack_bank_unit sp_bank_checks u_chk (
    .clk             (clk),
    .rst             (rst),
    .handler_mode    (handler_mode),
    .thread_use_proc (thread_use_proc),
    .stack_op        (stack_op),
    .push_data       (push_data),
    .gen_rd_data     (gen_rd_data),
    .spec_wr_en      (spec_wr_en),
    .spec_wr_sel     (spec_wr_sel),
    .spec_wr_data    (spec_wr_data),
    .spec_rd_sel     (spec_rd_sel),
    .spec_rd_data    (spec_rd_data),
    .active_bank     (active_bank),
    .mem_addr        (mem_addr),
    .mem_wr          (mem_wr),
    .mem_rd          (mem_rd),
    .mem_wdata       (mem_wdata),
    .conflict_err    (conflict_err)
);

// File: tb/stack_bank_unit_tb.sv
`timescale 1ns/1ps
module stack_bank_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] main_reset_val;
    logic        handler_mode, thread_use_proc;
    logic [1:0]  stack_op;
    logic [31:0] push_data;
    logic        gen_wr_en;
    logic [31:0] gen_wr_data, gen_rd_data;
    logic        spec_wr_en, spec_wr_sel, spec_rd_sel;
    logic [31:0] spec_wr_data, spec_rd_data;
    logic        active_bank;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_wr, mem_rd, conflict_err;

    always #2 clk = ~clk;

    stack_bank_unit u_dut (
        .clk(clk), .rst(rst), .main_reset_val(main_reset_val),
        .handler_mode(handler_mode), .thread_use_proc(thread_use_proc),
        .stack_op(stack_op), .push_data(push_data),
        .gen_wr_en(gen_wr_en), .gen_wr_data(gen_wr_data), .gen_rd_data(gen_rd_data),
        .spec_wr_en(spec_wr_en), .spec_wr_sel(spec_wr_sel), .spec_wr_data(spec_wr_data),
        .spec_rd_sel(spec_rd_sel), .spec_rd_data(spec_rd_data),
        .active_bank(active_bank), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_wdata(mem_wdata), .conflict_err(conflict_err)
    );

    typedef struct {
        string       tag;
        logic [31:0] gen, spec, addr, wdata;
        logic        wr, rd, cf, act;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] m_main, m_proc;
    bit          finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "gen_rd_data",  gen_rd_data,  e.gen);
            chk(e.tag, "spec_rd_data", spec_rd_data, e.spec);
            chk(e.tag, "active_bank",  {31'd0, active_bank},  {31'd0, e.act});
            chk(e.tag, "mem_wr",       {31'd0, mem_wr},       {31'd0, e.wr});
            chk(e.tag, "mem_rd",       {31'd0, mem_rd},       {31'd0, e.rd});
            chk(e.tag, "conflict_err", {31'd0, conflict_err}, {31'd0, e.cf});
            if (e.wr || e.rd) chk(e.tag, "mem_addr", mem_addr, e.addr);
            if (e.wr)         chk(e.tag, "mem_wdata", mem_wdata, e.wdata);
        end
    end

    task automatic step(input string tag, input logic [1:0] op, input logic [31:0] pd,
                        input logic hm, input logic ts,
                        input logic gwe, input logic [31:0] gwd,
                        input logic swe, input logic ss, input logic [31:0] swd,
                        input logic rs);
        exp_t        e;
        logic        act, xfer;
        logic [31:0] cur, nxt;
        @(negedge clk);
        stack_op = op; push_data = pd; handler_mode = hm; thread_use_proc = ts;
        gen_wr_en = gwe; gen_wr_data = gwd; spec_wr_en = swe; spec_wr_sel = ss;
        spec_wr_data = swd; spec_rd_sel = rs;
        act  = hm ? 1'b0 : ts;
        cur  = act ? m_proc : m_main;
        xfer = (op == 2'b01) || (op == 2'b10);
        e.tag   = tag;
        e.act   = act;
        e.gen   = cur;
        e.spec  = rs ? m_proc : m_main;
        e.cf    = xfer && (gwe || (swe && ss == act));
        e.wr    = (op == 2'b01) && !e.cf;
        e.rd    = (op == 2'b10) && !e.cf;
        e.addr  = (op == 2'b01) ? cur - 32'd4 : cur;
        e.wdata = pd;
        sb.push_back(e);
        nxt = cur;
        if (e.wr) nxt = cur - 32'd4;
        if (e.rd) nxt = cur + 32'd4;
        if (gwe)  nxt = gwd & ~32'h3;
        if (act) m_proc = nxt; else m_main = nxt;
        if (swe) begin
            if (ss) m_proc = swd & ~32'h3;
            else    m_main = swd & ~32'h3;
        end
    endtask

    task automatic do_reset(input logic [31:0] rv);
        @(negedge clk);
        rst = 1'b1; main_reset_val = rv;
        stack_op = 2'b00; gen_wr_en = 1'b0; spec_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_main = rv & ~32'h3;
        m_proc = 32'd0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; main_reset_val = 32'h2000_0403;
        handler_mode = 1'b0; thread_use_proc = 1'b0; stack_op = 2'b00;
        push_data = '0; gen_wr_en = 1'b0; gen_wr_data = '0;
        spec_wr_en = 1'b0; spec_wr_sel = 1'b0; spec_wr_data = '0; spec_rd_sel = 1'b0;
        do_reset(32'h2000_0403);
        // R1: reset values seen on both read ports
        step("R1 reset main", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        step("R1 reset proc", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b1);
        // R4: low bits dropped on write
        step("R4 gen write unaligned", 2'b00, 0, 1'b0, 1'b0, 1, 32'h1234_5677, 0, 0, 0, 1'b0);
        step("R4 readback", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        // R5 / R6: push twice, pop twice on main
        step("R5 push a", 2'b01, 32'hAAAA_0001, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        step("R5 push b", 2'b01, 32'hBBBB_0002, 1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b0);
        step("R6 pop b",  2'b10, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        step("R6 pop a",  2'b10, 0, 1'b1, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        // R2: selection
        step("R2 thread proc", 2'b00, 0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b0);
        step("R2 handler overrides", 2'b00, 0, 1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b1);
        // R5: push from zero wraps
        step("R5 push wrap proc", 2'b01, 32'hCAFE_F00D, 1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b1);
        step("R6 pop wrap proc", 2'b10, 0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b1);
        // R3: gen write hits only active bank
        step("R3 gen write proc", 2'b00, 0, 1'b0, 1'b1, 1, 32'h0000_8000, 0, 0, 0, 1'b0);
        step("R3 main untouched", 2'b00, 0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b0);
        // R8: named access in handler mode
        step("R8 spec write proc", 2'b00, 0, 1'b1, 1'b0, 0, 0, 1, 1'b1, 32'h0000_9006, 1'b1);
        step("R8 spec read proc", 2'b00, 0, 1'b1, 1'b0, 0, 0, 0, 0, 0, 1'b1);
        // R7: reserved op is idle
        step("R7 reserved op", 2'b11, 32'hDEAD_BEEF, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        step("R7 after reserved", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b1);
        // R9: push + named write same bank
        step("R9 push vs spec", 2'b01, 32'h1111_1111, 1'b0, 1'b0, 0, 0, 1, 1'b0, 32'h0000_4000, 1'b0);
        step("R9 after", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        // R10: pop + gen write; spec beats gen on same bank
        step("R10 pop vs gen", 2'b10, 0, 1'b0, 1'b1, 1, 32'h0000_A000, 0, 0, 0, 1'b1);
        step("R10 after", 2'b00, 0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b1);
        step("R10 spec beats gen", 2'b00, 0, 1'b0, 1'b1, 1, 32'h0000_B000, 1, 1'b1, 32'h0000_C000, 1'b1);
        step("R10 spec kept", 2'b00, 0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b1);
        // R11: transfer plus named write to other bank
        step("R11 push + spec other", 2'b01, 32'h2222_2222, 1'b1, 1'b1, 0, 0, 1, 1'b1, 32'h0000_D000, 1'b1);
        step("R11 after main", 2'b00, 0, 1'b1, 1'b0, 0, 0, 0, 0, 0, 1'b1);
        // R1: reset mid-run restores both
        do_reset(32'h0001_0000);
        step("R1 re-reset", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b1);
        step("R1 re-reset main", 2'b00, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule